// File: doc/BRIEF.md
# Trap and Return Control Coprocessor

This block is the system-control coprocessor beside the pipeline controller of a 32-bit load/store core. Each cycle the controller hands it a small set of decoded strobes: a trap request carrying a 4-bit trap code, an exception-return strobe, and a move-to-coprocessor strobe. With them come the address of the current instruction, a register index, the write data, and the two source operand values used by the equal-compare trap. The block owns three architectural registers: the status word, the cause word and the saved exception PC.

When a trap is taken, the block tells the fetch stage in the same cycle to redirect, and it supplies the fixed handler vector as the target. On the following clock edge it saves the trapping instruction's address, records the trap code in the cause word and shifts the status word left to mask interrupts. An exception return redirects fetch to the saved PC and shifts the status word back to the right. A move-from-coprocessor reads any of the three registers through a combinational read port. The controller then writes that value into a general register.

Top module: `sysctl_cop`

## Requirements
- R1: Synchronous active-high reset clears the status, cause and exception-PC registers, so reading indices 12, 13 and 14 returns 0.
- R2: A trap request is taken for code 4'b1000 (system call) and 4'b1001 (breakpoint) unconditionally, and for code 4'b1101 (equal trap) only when src_a equals src_b. For code 0, any other code, or a false equal trap, no trap is taken. When a trap is taken, pc_redirect is 1 in the same cycle and redirect_addr is 32'h0040_0004.
- R3: On a taken trap, the exception-PC register (index 14) takes the value of cur_pc at the next clock edge.
- R4: On a taken trap, bits 6:2 of the cause register (index 13) become the trap code zero-extended to 5 bits. All other cause bits keep their value.
- R5: On a taken trap, the status register (index 12) is shifted left by 5 bits with zero fill.
- R6: An exception return raises pc_redirect in the same cycle, with redirect_addr equal to the current exception-PC value. At the next edge the status register is shifted right by 5 bits with zero fill.
- R7: A move-to writes wr_data to index 12 (status), 13 (cause) or 14 (exception PC) at the next edge. A move-to aimed at any other index changes no register.
- R8: rd_data combinationally returns the register selected by reg_idx for indices 12, 13 and 14, and returns 0 for every other index.
- R9: In one cycle, a taken trap wins over an exception return, and an exception return wins over a move-to. A trap request that is not taken does not block a return or a move-to issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request strobe from the controller |
| trap_code | input | 4 | Trap code accompanying trap_req |
| src_a | input | 32 | First source operand for the equal trap |
| src_b | input | 32 | Second source operand for the equal trap |
| mtc_req | input | 1 | Move-to-coprocessor strobe |
| eret_req | input | 1 | Exception-return strobe |
| cur_pc | input | 32 | Address of the instruction being executed |
| reg_idx | input | 5 | Coprocessor register index for read and write |
| wr_data | input | 32 | Move-to write data |
| pc_redirect | output | 1 | Fetch must take redirect_addr instead of PC+4 |
| redirect_addr | output | 32 | Handler vector on a trap, saved PC on a return |
| rd_data | output | 32 | Move-from read data for reg_idx |

## Verification
A wrong internal state in this block shows up at the ports one clock after the faulty update, at the latest. Any register can be read back on the cycle after a trap, return or write. A corrupted exception PC also appears directly on redirect_addr during the next return. A bad trap decision is visible in the same cycle on pc_redirect, and one cycle later as an unexpected change in the shifted status or in the cause field. The sweeps cover every trap code with both equal and unequal operands, and every register index for writes and reads, so each of these paths is compared against a model built from the requirements.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam logic [3:0] CODE_NONE    = 4'b0000;
    localparam logic [3:0] CODE_SYSCALL = 4'b1000;
    localparam logic [3:0] CODE_BREAK   = 4'b1001;
    localparam logic [3:0] CODE_TEQ     = 4'b1101;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_ENTER  = 2'd1,
        OP_RETURN = 2'd2,
        OP_WRITE  = 2'd3
    } cop_op_e;

    typedef struct packed {
        cop_op_e    op;
        logic [3:0] code;
    } cop_cmd_t;

    // Whether a trap code leads to a taken trap, given operand equality.
    function automatic logic code_fires(input logic [3:0] code, input logic operands_eq);
        case (code)
            CODE_SYSCALL, CODE_BREAK: return 1'b1;
            CODE_TEQ:                 return operands_eq;
            default:                  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          trap_req,
    input  logic [3:0]    trap_code,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic          mtc_req,
    input  logic          eret_req,
    output cop_cmd_t      cmd
);

    logic operands_eq;
    logic trap_taken;

    assign operands_eq = (src_a == src_b);
    assign trap_taken  = trap_req && code_fires(trap_code, operands_eq);

    // Fixed priority: taken trap, then return, then register write.
    always_comb begin
        cmd.code = trap_code;
        if (trap_taken) begin
            cmd.op = OP_ENTER;
        end else if (eret_req) begin
            cmd.op = OP_RETURN;
        end else if (mtc_req) begin
            cmd.op = OP_WRITE;
        end else begin
            cmd.op = OP_IDLE;
        end
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int DW        = 32,
    parameter int IDX_W     = 5,
    parameter int IDX_FIRST = 12,
    parameter int SHIFT     = 5,
    parameter int CAUSE_LSB = 2,
    parameter int CAUSE_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  cop_cmd_t         cmd,
    input  logic [DW-1:0]    cur_pc,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    status_q,
    output logic [DW-1:0]    cause_q,
    output logic [DW-1:0]    epc_q
);

    localparam int CAUSE_MSB = CAUSE_LSB + CAUSE_W - 1;
    localparam logic [IDX_W-1:0] SEL_STATUS = IDX_W'(IDX_FIRST);
    localparam logic [IDX_W-1:0] SEL_CAUSE  = IDX_W'(IDX_FIRST + 1);
    localparam logic [IDX_W-1:0] SEL_EPC    = IDX_W'(IDX_FIRST + 2);

    logic [DW-1:0] cause_entry;

    // Cause word with only the code field replaced.
    always_comb begin
        cause_entry                      = cause_q;
        cause_entry[CAUSE_MSB:CAUSE_LSB] = CAUSE_W'(cmd.code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            cause_q  <= '0;
            epc_q    <= '0;
        end else begin
            case (cmd.op)
                OP_ENTER: begin
                    epc_q    <= cur_pc;
                    cause_q  <= cause_entry;
                    status_q <= status_q << SHIFT;
                end
                OP_RETURN: begin
                    status_q <= status_q >> SHIFT;
                end
                OP_WRITE: begin
                    if (reg_idx == SEL_STATUS) status_q <= wr_data;
                    if (reg_idx == SEL_CAUSE)  cause_q  <= wr_data;
                    if (reg_idx == SEL_EPC)    epc_q    <= wr_data;
                end
                default: begin
                end
            endcase
        end
    end

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_ENTER) |=> (epc_q == $past(cur_pc))); // R3

    AST_CAUSE_FIELD: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_ENTER) |=> (cause_q[CAUSE_MSB:CAUSE_LSB] == CAUSE_W'($past(cmd.code)))); // R4

    AST_CAUSE_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_ENTER) |=> (cause_q[CAUSE_LSB-1:0] == $past(cause_q[CAUSE_LSB-1:0]))); // R4

    AST_STATUS_MASK: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_ENTER) |=> (status_q == ($past(status_q) << SHIFT))); // R5

    AST_STATUS_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_RETURN) |=> (status_q == ($past(status_q) >> SHIFT))); // R6

    AST_RETURN_KEEPS_EPC: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_RETURN) |=> $stable(epc_q)); // R9

endmodule

// File: rtl/sysctl_readout.sv
module sysctl_readout
    import sysctl_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          IDX_W     = 5,
    parameter int          IDX_FIRST = 12,
    parameter logic [31:0] VECTOR    = 32'h0040_0004
) (
    input  cop_op_e          op,
    input  logic [DW-1:0]    status_q,
    input  logic [DW-1:0]    cause_q,
    input  logic [DW-1:0]    epc_q,
    input  logic [IDX_W-1:0] reg_idx,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    redirect_addr,
    output logic             pc_redirect
);

    localparam int NREG = 3;

    logic [NREG-1:0][DW-1:0] bank;
    logic [NREG-1:0][DW-1:0] term;

    assign bank = {epc_q, cause_q, status_q};

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign term[g] = (reg_idx == IDX_W'(IDX_FIRST + g)) ? bank[g] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++) begin
            rd_data = rd_data | term[k];
        end
    end

    assign pc_redirect   = (op == OP_ENTER) || (op == OP_RETURN);
    assign redirect_addr = (op == OP_RETURN) ? epc_q : DW'(VECTOR);

endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
    import sysctl_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          IDX_W     = 5,
    parameter int          IDX_FIRST = 12,
    parameter int          SHIFT     = 5,
    parameter int          CAUSE_LSB = 2,
    parameter int          CAUSE_W   = 5,
    parameter logic [31:0] VECTOR    = 32'h0040_0004
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_req,
    input  logic [3:0]       trap_code,
    input  logic [DW-1:0]    src_a,
    input  logic [DW-1:0]    src_b,
    input  logic             mtc_req,
    input  logic             eret_req,
    input  logic [DW-1:0]    cur_pc,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DW-1:0]    wr_data,
    output logic             pc_redirect,
    output logic [DW-1:0]    redirect_addr,
    output logic [DW-1:0]    rd_data
);

    cop_cmd_t      cmd;
    logic [DW-1:0] status_q;
    logic [DW-1:0] cause_q;
    logic [DW-1:0] epc_q;

    sysctl_decode #(.DW(DW)) i_decode (
        .trap_req  (trap_req),
        .trap_code (trap_code),
        .src_a     (src_a),
        .src_b     (src_b),
        .mtc_req   (mtc_req),
        .eret_req  (eret_req),
        .cmd       (cmd)
    );

    sysctl_regfile #(
        .DW(DW), .IDX_W(IDX_W), .IDX_FIRST(IDX_FIRST),
        .SHIFT(SHIFT), .CAUSE_LSB(CAUSE_LSB), .CAUSE_W(CAUSE_W)
    ) i_regfile (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cur_pc   (cur_pc),
        .reg_idx  (reg_idx),
        .wr_data  (wr_data),
        .status_q (status_q),
        .cause_q  (cause_q),
        .epc_q    (epc_q)
    );

    sysctl_readout #(
        .DW(DW), .IDX_W(IDX_W), .IDX_FIRST(IDX_FIRST), .VECTOR(VECTOR)
    ) i_readout (
        .op            (cmd.op),
        .status_q      (status_q),
        .cause_q       (cause_q),
        .epc_q         (epc_q),
        .reg_idx       (reg_idx),
        .rd_data       (rd_data),
        .redirect_addr (redirect_addr),
        .pc_redirect   (pc_redirect)
    );

    AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (!trap_req && !eret_req) |-> !pc_redirect); // R2

    AST_ZERO_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (trap_req && trap_code == CODE_NONE && !eret_req) |-> !pc_redirect); // R2

    AST_SYSCALL_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (trap_req && trap_code == CODE_SYSCALL) |-> (pc_redirect && redirect_addr == DW'(VECTOR))); // R2

    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (rst)
        (eret_req && !trap_req) |-> (pc_redirect && redirect_addr == epc_q)); // R6

    AST_IGNORED_INDEX: assert property (@(posedge clk) disable iff (rst)
        (mtc_req && !trap_req && !eret_req &&
         (reg_idx < IDX_W'(IDX_FIRST) || reg_idx > IDX_W'(IDX_FIRST + 2)))
        |=> ($stable(status_q) && $stable(cause_q) && $stable(epc_q))); // R7

endmodule

// File: tb/test_sysctl_cop.sv
module test_sysctl_cop;

    logic        clk = 1'b0;
    logic        rst;
    logic        trap_req;
    logic [3:0]  trap_code;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic        mtc_req;
    logic        eret_req;
    logic [31:0] cur_pc;
    logic [4:0]  reg_idx;
    logic [31:0] wr_data;
    logic        pc_redirect;
    logic [31:0] redirect_addr;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_status;
    logic [31:0] m_cause;
    logic [31:0] m_epc;

    localparam logic [31:0] HANDLER = 32'h0040_0004;

    always #4 clk = ~clk;

    sysctl_cop i_sysctl_cop (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_code(trap_code),
        .src_a(src_a), .src_b(src_b), .mtc_req(mtc_req), .eret_req(eret_req),
        .cur_pc(cur_pc), .reg_idx(reg_idx), .wr_data(wr_data),
        .pc_redirect(pc_redirect), .redirect_addr(redirect_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] idx);
        case (idx)
            5'd12:   return m_status;
            5'd13:   return m_cause;
            5'd14:   return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    // One command cycle: drive, check same-cycle redirect, update model.
    task automatic cycle(input logic tr, input logic [3:0] code, input logic [31:0] a,
                         input logic [31:0] b, input logic mt, input logic er,
                         input logic [31:0] pc, input logic [4:0] idx,
                         input logic [31:0] wd, input string req);
        logic        take;
        logic [31:0] exp_addr;
        @(negedge clk);
        trap_req = tr; trap_code = code; src_a = a; src_b = b;
        mtc_req = mt; eret_req = er; cur_pc = pc; reg_idx = idx; wr_data = wd;
        #1;
        take = tr && (code == 4'b1000 || code == 4'b1001 || (code == 4'b1101 && a == b));
        exp_addr = (!take && er) ? m_epc : HANDLER;
        check(req, {31'b0, pc_redirect}, {31'b0, (take || er)});
        if (take || er) check(req, redirect_addr, exp_addr);
        if (take) begin
            m_epc    = pc;
            m_cause  = (m_cause & ~(32'h1F << 2)) | ({28'b0, code} << 2);
            m_status = m_status << 5;
        end else if (er) begin
            m_status = m_status >> 5;
        end else if (mt) begin
            if (idx == 5'd12) m_status = wd;
            if (idx == 5'd13) m_cause  = wd;
            if (idx == 5'd14) m_epc    = wd;
        end
    endtask

    task automatic read_chk(input logic [4:0] idx, input string req);
        @(negedge clk);
        trap_req = 1'b0; mtc_req = 1'b0; eret_req = 1'b0; reg_idx = idx;
        #1;
        check(req, rd_data, model_read(idx));
        check(req, {31'b0, pc_redirect}, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trap_req = 1'b0; mtc_req = 1'b0; eret_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_status = '0; m_cause = '0; m_epc = '0;
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; trap_req = 1'b0; trap_code = '0; src_a = '0; src_b = '0;
        mtc_req = 1'b0; eret_req = 1'b0; cur_pc = '0; reg_idx = '0; wr_data = '0;
        m_status = '0; m_cause = '0; m_epc = '0;
        do_reset();
        // R1: reset state
        read_chk(5'd12, "R1");
        read_chk(5'd13, "R1");
        read_chk(5'd14, "R1");

        // R2/R3/R4/R5/R6: every trap code, equal and unequal operands
        for (int c = 0; c < 16; c++) begin
            for (int e = 0; e < 2; e++) begin
                cycle(0, 4'h0, 0, 0, 1, 0, 0, 5'd12, 32'h8765_4321 ^ 32'(c), "R7");
                cycle(0, 4'h0, 0, 0, 1, 0, 0, 5'd13, 32'hFFFF_FFFF, "R7");
                cycle(0, 4'h0, 0, 0, 1, 0, 0, 5'd14, 32'h1234_0000 + 32'(c), "R7");
                cycle(1, 4'(c), 32'(c * 3), 32'(c * 3 + 1 - e), 0, 0,
                      32'h0040_1000 + 32'(c * 16 + e * 4), 5'd0, 0, "R2");
                read_chk(5'd12, "R5");
                read_chk(5'd13, "R4");
                read_chk(5'd14, "R3");
                cycle(0, 4'h0, 0, 0, 0, 1, 0, 5'd0, 0, "R6");
                read_chk(5'd12, "R6");
            end
        end

        // R7/R8: every index written and read back
        for (int i = 0; i < 32; i++) begin
            cycle(0, 4'h0, 0, 0, 1, 0, 0, 5'(i), 32'hC0DE_0000 | 32'(i * 37), "R7");
            read_chk(5'(i), "R8");
            read_chk(5'd12, "R7");
            read_chk(5'd13, "R7");
            read_chk(5'd14, "R7");
        end

        // R9: same-cycle priority
        cycle(0, 4'h0, 0, 0, 1, 0, 0, 5'd12, 32'hF0F0_F0F0, "R7");
        cycle(1, 4'b1000, 0, 0, 1, 1, 32'h0040_2000, 5'd12, 32'h1111_1111, "R9");
        read_chk(5'd12, "R9");
        read_chk(5'd14, "R9");
        cycle(1, 4'h0, 0, 0, 1, 1, 32'h0040_3000, 5'd14, 32'h2222_2222, "R9");
        read_chk(5'd12, "R9");
        read_chk(5'd14, "R9");
        cycle(1, 4'b1101, 5, 6, 1, 0, 32'h0040_4000, 5'd13, 32'h3333_3333, "R9");
        read_chk(5'd13, "R9");
        read_chk(5'd14, "R9");

        // R1: reset after activity
        do_reset();
        read_chk(5'd12, "R1");
        read_chk(5'd13, "R1");
        read_chk(5'd14, "R1");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule